// File: doc/BRIEF.md
# eMMC Card Hardware Reset Sequencer

This block runs the host-side hardware reset of an eMMC card when asked to. A single-cycle `start` request latches the target slot, whether the descriptor-DMA engine is in use, and the card-clock period expressed in system-clock cycles. The block then clears the controller's own datapath. If descriptor DMA is in use, it first gives a one-cycle software-reset pulse to that engine. It then asserts a combined DMA+FIFO reset request and holds it until the controller acknowledges. No stop command is sent and the block does not wait for a transfer to finish. It goes straight to these internal resets.

Once the acknowledge arrives, the active-low reset pin of the chosen slot is pulled low. It stays low for the longer of 1 µs and one card-clock period. The pin is then released, and a per-slot command-inhibit flag is held for 200 µs so the card can finish its internal reset. All durations are whole system-clock cycles, rounded up from `CLK_FREQ_HZ`. If the acknowledge never arrives, the sequence gives up with an error and the pin is never touched. All control and status pins are plain levels or single-cycle pulses. There is no streaming data path and no back-pressure.

Top module: `emmc_hwrst_seq`

## Requirements
- R1: After system reset every `card_rst_n` bit is 1 (released), every `cmd_inhibit` bit is 0, and `busy`, `done`, `error`, `dma_swrst` and `ctrl_rst_req` are 0.
- R2: A `start` seen while idle is accepted and `busy` is 1 from the next cycle until the sequence ends. A `start` seen while `busy` is 1 is ignored, and its slot, mode and period inputs have no effect on the running sequence.
- R3: When `dma_mode` is 1 at acceptance, `dma_swrst` is 1 for exactly the one cycle after acceptance. When `dma_mode` is 0, `dma_swrst` stays 0.
- R4: `ctrl_rst_req` rises right after acceptance (or right after the `dma_swrst` cycle) and stays 1 until `ctrl_rst_done` is sampled 1. The pin pulse starts the next cycle.
- R5: If `ctrl_rst_done` is not sampled 1 within `ACK_TIMEOUT` cycles of `ctrl_rst_req`, then `error` pulses for one cycle as the block returns to idle. No `card_rst_n` bit goes low and no `cmd_inhibit` bit is set.
- R6: `card_rst_n[i]` = 0 holds slot i's card in reset and 1 releases it. Only the bit at the latched slot index ever goes to 0.
- R7: The selected bit stays 0 for exactly max(ceil(CLK_FREQ_HZ/1e6), `cclk_cycles`) cycles.
- R8: `cmd_inhibit` at the latched slot index is 1 for exactly ceil(200e-6·CLK_FREQ_HZ) cycles, starting the cycle the pin is released. All other `cmd_inhibit` bits stay 0.
- R9: `done` is a one-cycle pulse in the first idle cycle after the command lockout, and `busy` is 0 in that cycle.
- R10: Between a release and any later low pulse on `card_rst_n`, the pins stay high for at least ceil(CLK_FREQ_HZ/1e6) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| start | input | 1 | Single-cycle request to begin a card reset |
| slot_sel | input | SLOT_W | Target slot index, latched at acceptance |
| dma_mode | input | 1 | 1 when the descriptor-DMA engine is in use |
| cclk_cycles | input | CCLK_W | Card-clock period in system-clock cycles |
| dma_swrst | output | 1 | One-cycle software-reset pulse to the descriptor-DMA engine |
| ctrl_rst_req | output | 1 | Combined DMA+FIFO reset request, held until acknowledged |
| ctrl_rst_done | input | 1 | Acknowledge from the DMA/FIFO reset logic |
| card_rst_n | output | NUM_SLOTS | Per-slot active-low card reset pins |
| cmd_inhibit | output | NUM_SLOTS | Per-slot command lockout after release |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the lockout ends |
| error | output | 1 | One-cycle pulse when the acknowledge times out |

## Verification
The sequence is run with descriptor DMA on and off, to tell the optional software-reset step apart from the direct path. The card-clock period is set below, equal to and above the 1 µs floor, which checks that the longer limit sets the low time. The acknowledge is given at once, after a few cycles, in the last allowed cycle, and never. These show that late acknowledges are still taken and that a missing one aborts with the pins untouched. One run repeatedly re-requests with a different slot and mode while busy, to show those requests leave the running sequence unchanged.

// File: rtl/emmc_hwrst_pkg.sv
package emmc_hwrst_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DMA_SW,
    ST_CTRL,
    ST_PIN_LOW,
    ST_LOCK
  } seq_state_e;

  // whole clock cycles covering dur_ns at hz, rounded up
  function automatic longint unsigned cycles_ceil(input longint unsigned hz,
                                                  input longint unsigned dur_ns);
    return (hz * dur_ns + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction

endpackage

// File: rtl/hwrst_timer.sv
module hwrst_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end

  assign expire = (cnt_q == limit - 1'b1);
endmodule

// File: rtl/hwrst_fsm.sv
module hwrst_fsm
  import emmc_hwrst_pkg::*;
#(
  parameter int SLOT_W = 2,
  parameter int CCLK_W = 8,
  parameter int TW     = 16,
  parameter int C1US   = 10,
  parameter int C200US = 2000,
  parameter int ACK_TO = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [SLOT_W-1:0] slot_sel,
  input  logic              dma_mode,
  input  logic [CCLK_W-1:0] cclk_cycles,
  input  logic              ctrl_rst_done,
  input  logic              tmr_expire,
  output logic              tmr_restart,
  output logic [TW-1:0]     tmr_limit,
  output logic [SLOT_W-1:0] slot_q,
  output logic              pin_low,
  output logic              lock_on,
  output logic              dma_swrst,
  output logic              ctrl_rst_req,
  output logic              busy,
  output logic              done,
  output logic              error
);
  seq_state_e    state_q, state_d;
  logic [TW-1:0] low_q;
  logic          done_q, err_q;
  logic          accept;

  assign accept = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start) state_d = dma_mode ? ST_DMA_SW : ST_CTRL;
      ST_DMA_SW:  state_d = ST_CTRL;
      ST_CTRL: begin
        if (ctrl_rst_done)   state_d = ST_PIN_LOW;
        else if (tmr_expire) state_d = ST_IDLE;
      end
      ST_PIN_LOW: if (tmr_expire) state_d = ST_LOCK;
      ST_LOCK:    if (tmr_expire) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_CTRL:    tmr_limit = TW'(ACK_TO);
      ST_PIN_LOW: tmr_limit = low_q;
      ST_LOCK:    tmr_limit = TW'(C200US);
      default:    tmr_limit = '1;
    endcase
  end

  assign tmr_restart = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      low_q   <= TW'(C1US);
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_LOCK) && tmr_expire;
      err_q   <= (state_q == ST_CTRL) && !ctrl_rst_done && tmr_expire;
      if (accept) begin
        slot_q <= slot_sel;
        low_q  <= (TW'(cclk_cycles) > TW'(C1US)) ? TW'(cclk_cycles) : TW'(C1US);
      end
    end
  end

  assign pin_low      = (state_q == ST_PIN_LOW);
  assign lock_on      = (state_q == ST_LOCK);
  assign dma_swrst    = (state_q == ST_DMA_SW);
  assign ctrl_rst_req = (state_q == ST_CTRL);
  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign error        = err_q;

  // R2
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(slot_q));
  // R3
  dma_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !dma_mode) |=> !dma_swrst);
  // R5
  ack_timeout_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rst_req && tmr_expire && !ctrl_rst_done) |=> (error && !busy));
  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/hwrst_pin_bank.sv
module hwrst_pin_bank #(
  parameter int NUM_SLOTS = 4,
  parameter int SLOT_W    = 2
) (
  input  logic                 pin_low,
  input  logic                 lock_on,
  input  logic [SLOT_W-1:0]    slot_q,
  output logic [NUM_SLOTS-1:0] card_rst_n,
  output logic [NUM_SLOTS-1:0] cmd_inhibit
);
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    logic hit;
    assign hit            = (slot_q == SLOT_W'(i));
    assign card_rst_n[i]  = !(pin_low && hit);
    assign cmd_inhibit[i] = lock_on && hit;
  end
endmodule

// File: rtl/emmc_hwrst_seq.sv
module emmc_hwrst_seq
  import emmc_hwrst_pkg::*;
#(
  parameter longint unsigned CLK_FREQ_HZ = 100_000_000,
  parameter int NUM_SLOTS   = 2,
  parameter int CCLK_W      = 8,
  parameter int ACK_TIMEOUT = 64,
  localparam int SLOT_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [SLOT_W-1:0]    slot_sel,
  input  logic                 dma_mode,
  input  logic [CCLK_W-1:0]    cclk_cycles,
  output logic                 dma_swrst,
  output logic                 ctrl_rst_req,
  input  logic                 ctrl_rst_done,
  output logic [NUM_SLOTS-1:0] card_rst_n,
  output logic [NUM_SLOTS-1:0] cmd_inhibit,
  output logic                 busy,
  output logic                 done,
  output logic                 error
);
  localparam int C1US   = int'(cycles_ceil(CLK_FREQ_HZ, 64'd1_000));
  localparam int C200US = int'(cycles_ceil(CLK_FREQ_HZ, 64'd200_000));
  localparam int MAXC_A = (C200US > (1 << CCLK_W)) ? C200US : (1 << CCLK_W);
  localparam int MAXC   = (MAXC_A > ACK_TIMEOUT) ? MAXC_A : ACK_TIMEOUT;
  localparam int TW     = $clog2(MAXC + 1) + 1;

  logic              tmr_restart, tmr_expire;
  logic [TW-1:0]     tmr_limit;
  logic [SLOT_W-1:0] slot_q;
  logic              pin_low, lock_on;

  hwrst_fsm #(
    .SLOT_W(SLOT_W), .CCLK_W(CCLK_W), .TW(TW),
    .C1US(C1US), .C200US(C200US), .ACK_TO(ACK_TIMEOUT)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .slot_sel(slot_sel),
    .dma_mode(dma_mode), .cclk_cycles(cclk_cycles),
    .ctrl_rst_done(ctrl_rst_done), .tmr_expire(tmr_expire),
    .tmr_restart(tmr_restart), .tmr_limit(tmr_limit), .slot_q(slot_q),
    .pin_low(pin_low), .lock_on(lock_on), .dma_swrst(dma_swrst),
    .ctrl_rst_req(ctrl_rst_req), .busy(busy), .done(done), .error(error)
  );

  hwrst_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(tmr_restart),
    .limit(tmr_limit), .expire(tmr_expire)
  );

  hwrst_pin_bank #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_pins (
    .pin_low(pin_low), .lock_on(lock_on), .slot_q(slot_q),
    .card_rst_n(card_rst_n), .cmd_inhibit(cmd_inhibit)
  );

  // pin-width watch: run lengths of low and high pin periods
  logic [NUM_SLOTS-1:0] prev_pins;
  logic [TW-1:0]        low_run, high_run;
  logic                 all_high;
  assign all_high = &card_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_pins <= '1;
      low_run   <= '0;
      high_run  <= '1;
    end else begin
      prev_pins <= card_rst_n;
      low_run   <= all_high ? '0 : low_run + 1'b1;
      high_run  <= !all_high ? '0 : ((&high_run) ? high_run : high_run + 1'b1);
    end
  end

  // R6
  one_slot_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~card_rst_n) <= 1);
  // R7
  low_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (all_high && !(&prev_pins)) |-> (low_run >= TW'(C1US)));
  // R10
  high_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_high && (&prev_pins)) |-> (high_run >= TW'(C1US)));
  // R8
  inhibit_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|cmd_inhibit) |-> !(&prev_pins));
endmodule

// File: tb/emmc_hwrst_seq_tb.sv
module emmc_hwrst_seq_tb;
  localparam longint unsigned FREQ = 10_000_000; // block timing scaled: 1 us = 10 cycles
  localparam int NS   = 4;
  localparam int CW   = 8;
  localparam int TO   = 16;
  localparam int C1   = 10;
  localparam int C200 = 2000;

  logic clk = 0, rst_n = 0;
  logic start = 0, dma_mode = 0, ctrl_rst_done = 0;
  logic [1:0] slot_sel = 0;
  logic [CW-1:0] cclk_cycles = 0;
  logic dma_swrst, ctrl_rst_req, busy, done, error;
  logic [NS-1:0] card_rst_n, cmd_inhibit;

  int errors = 0, checks = 0;
  bit cmp_on = 0;

  always #5 clk = ~clk;

  emmc_hwrst_seq #(.CLK_FREQ_HZ(FREQ), .NUM_SLOTS(NS), .CCLK_W(CW), .ACK_TIMEOUT(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .slot_sel(slot_sel), .dma_mode(dma_mode),
    .cclk_cycles(cclk_cycles), .dma_swrst(dma_swrst), .ctrl_rst_req(ctrl_rst_req),
    .ctrl_rst_done(ctrl_rst_done), .card_rst_n(card_rst_n), .cmd_inhibit(cmd_inhibit),
    .busy(busy), .done(done), .error(error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle,1 dma sw,2 ctrl,3 pin low,4 lockout
  int m_ph = 0, m_left = 0, m_slot = 0;
  bit m_done = 0, m_err = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph <= 0; m_left <= 0; m_slot <= 0; m_done <= 0; m_err <= 0;
    end else begin
      m_done <= 0; m_err <= 0;
      case (m_ph)
        0: if (start) begin
             m_slot <= slot_sel; m_ph <= dma_mode ? 1 : 2; m_left <= TO;
             if (!dma_mode) m_left <= TO;
             // low time kept in m_slot's companion below
           end
        1: begin m_ph <= 2; m_left <= TO; end
        2: if (ctrl_rst_done) begin m_ph <= 3; m_left <= (int'(m_cc) > C1) ? int'(m_cc) : C1; end
           else if (m_left == 1) begin m_ph <= 0; m_err <= 1; end
           else m_left <= m_left - 1;
        3: if (m_left == 1) begin m_ph <= 4; m_left <= C200; end else m_left <= m_left - 1;
        4: if (m_left == 1) begin m_ph <= 0; m_done <= 1; end else m_left <= m_left - 1;
        default: m_ph <= 0;
      endcase
    end
  end
  int m_cc = 0;
  always @(posedge clk) if (rst_n && m_ph == 0 && start) m_cc <= int'(cclk_cycles);

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      logic [NS-1:0] e_pin, e_inh;
      for (int i = 0; i < NS; i++) begin
        e_pin[i] = !(m_ph == 3 && m_slot == i);
        e_inh[i] = (m_ph == 4 && m_slot == i);
      end
      chk(card_rst_n == e_pin, "R6 pins", card_rst_n, e_pin);
      chk(cmd_inhibit == e_inh, "R8 inhibit", cmd_inhibit, e_inh);
      chk(busy == (m_ph != 0), "R2 busy", busy, m_ph != 0);
      chk(dma_swrst == (m_ph == 1), "R3 dma_swrst", dma_swrst, m_ph == 1);
      chk(ctrl_rst_req == (m_ph == 2), "R4 ctrl_rst_req", ctrl_rst_req, m_ph == 2);
      chk(done == m_done, "R9 done", done, m_done);
      chk(error == m_err, "R5 error", error, m_err);
    end
  end

  task automatic run_case(input int slot, input bit dm, input int cc, input int ack_dly,
                          input int exp_low, input bit exp_ok, input bit poke);
    int n = 0, lowc = 0, inh = 0, dn = 0, er = 0, other = 0, sw = 0, gap = -1, k2 = 0;
    @(negedge clk);
    start = 1; slot_sel = 2'(slot); dma_mode = dm; cclk_cycles = CW'(cc);
    @(negedge clk);
    start = 0;
    for (int k = 0; k < 5000; k++) begin
      if (card_rst_n[slot] == 0) lowc++;
      if (cmd_inhibit[slot]) inh++;
      if ((card_rst_n | NS'(1 << slot)) != '1) other++;
      if ((cmd_inhibit & ~NS'(1 << slot)) != '0) other++;
      if (dma_swrst) sw++;
      if (ctrl_rst_req && gap < 0 && !dm) gap = k;
      dn += int'(done); er += int'(error);
      if (!busy) break;
      if (ctrl_rst_req) begin ctrl_rst_done = (ack_dly >= 0) && (n >= ack_dly); n++; end
      else ctrl_rst_done = 0;
      if (poke && (k % 7 == 3)) begin
        start = 1; slot_sel = 2'((slot + 1) % NS); dma_mode = !dm; cclk_cycles = 8'd200;
      end else start = 0;
      k2 = k;
      @(negedge clk);
    end
    start = 0; ctrl_rst_done = 0;
    chk(lowc == exp_low, "R7 low width", lowc, exp_low);
    chk(inh == (exp_ok ? C200 : 0), "R8 lockout length", inh, exp_ok ? C200 : 0);
    chk(dn == int'(exp_ok), "R9 done count", dn, int'(exp_ok));
    chk(er == int'(!exp_ok), "R5 error count", er, int'(!exp_ok));
    chk(other == 0, "R6 other slots untouched", other, 0);
    chk(sw == int'(dm), "R3 swrst cycles", sw, int'(dm));
    if (!dm) chk(gap == 0, "R4 req right after accept", gap, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(card_rst_n == '1, "R1 pins released", card_rst_n, 15);
    chk(cmd_inhibit == '0 && !busy && !done && !error && !dma_swrst && !ctrl_rst_req,
        "R1 idle outputs", {cmd_inhibit, busy, done, error, dma_swrst, ctrl_rst_req}, 0);
    rst_n = 1;
    cmp_on = 1;
    @(negedge clk);
    run_case(0, 1, 3, 2, C1, 1, 0);        // R7 floor wins, R3 dma step
    run_case(2, 0, 25, 0, 25, 1, 0);       // R7 card period wins, R4 immediate ack
    run_case(1, 1, C1, TO - 1, C1, 1, 1);  // R4 last-cycle ack, R2 pokes ignored
    run_case(3, 0, 40, -1, 0, 0, 0);       // R5 no ack: abort
    run_case(3, 0, 12, TO, 0, 0, 1);       // R5 ack one cycle late, R2 pokes ignored
    // R10 back-to-back: new run right after done keeps pins high long enough
    run_case(1, 0, 0, 1, C1, 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule